// File: doc/BRIEF.md
# Bidirectional Saturating Shift Unit

This block performs fixed-point shifts for speech-coding arithmetic on 16-bit and 32-bit signed operands. Each operation takes an operand, a signed 16-bit shift count and a two-bit opcode that selects the width and the nominal direction. A negative count turns the shift around and uses the magnitude of the count. Left shifts clamp to the most positive or most negative value of the operand width when significant bits would be lost. When that happens, the block raises a one-cycle flag that the surrounding datapath ORs into its sticky overflow bit. Right shifts are arithmetic and never overflow.

The unit sits in the first execute stage of a coprocessor pipeline. It accepts one operation per clock. The result and the flag are registered and appear one cycle after the operation is presented. Results of 16-bit operations are returned sign-extended to 32 bits, so the downstream write-back path is the same for both widths.

Top module: `sat_shift_unit`

## Requirements
- R1: `op` encoding: 2'b00 = 16-bit left, 2'b01 = 16-bit right, 2'b10 = 32-bit left, 2'b11 = 32-bit right. A 16-bit operation reads only `operand[15:0]`, ignores `operand[31:16]`, and returns its 16-bit result sign-extended to 32 bits.
- R2: When `in_valid` is high at a rising edge, `out_valid`, `result` and `ovf_set` for that operation appear after that edge (latency one). Otherwise `out_valid` is low after the edge. Synchronous reset drives `out_valid`, `result` and `ovf_set` to 0.
- R3: A left shift by n (n below the width) whose exact product value·2^n fits the signed range of the width returns that product with `ovf_set` low.
- R4: A left shift of a nonzero value whose exact product does not fit, or whose magnitude is at least the width (16 or 32), returns the largest positive value (0x7FFF / 0x7FFFFFFF) for a non-negative operand or the most negative value (0x8000 / 0x80000000, sign-extended) for a negative operand, with `ovf_set` high.
- R5: A left shift of a zero operand returns 0 with `ovf_set` low, for any magnitude.
- R6: A right shift is arithmetic. A magnitude of 15 or more (16-bit) or 31 or more (32-bit) yields 0 for a non-negative operand and all ones for a negative one. `ovf_set` is always low on right shifts.
- R7: A negative `amount` (two's complement) reverses the direction given by `op` and shifts by its magnitude. 0x8000 counts as a magnitude of 32768.
- R8: `ovf_set` is high only in a cycle where `out_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| op | input | 2 | Width and nominal direction select |
| operand | input | 32 | Value to shift (low 16 bits for 16-bit ops) |
| amount | input | 16 | Signed shift count |
| out_valid | output | 1 | Registered result valid |
| result | output | 32 | Registered shift result |
| ovf_set | output | 1 | Saturation occurred, to sticky overflow |

## Verification
The bench builds the unit with its default parameters: 16-bit short width, 32-bit long width and a 16-bit count. These values give it the exact boundaries of R4 and R6 (shift counts of 15, 16, 31 and 32) and the most negative count, 0x8000. Directed vectors cover products that just fit and products that just miss for both signs. Randomised operations mix both directions, both widths and negative counts. A reference model based on 64-bit integer multiplication checks every result.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    SH_L16 = 2'b00,
    SH_R16 = 2'b01,
    SH_L32 = 2'b10,
    SH_R32 = 2'b11
  } shift_op_e;
endpackage

// File: rtl/shamt_resolve.sv
// Turns the signed count plus the opcode direction into an effective
// direction and an unsigned magnitude.
module shamt_resolve #(
  parameter int AMT_W = 16
) (
  input  logic             op_right,
  input  logic [AMT_W-1:0] amount,
  output logic             go_left,
  output logic [AMT_W-1:0] mag
);
  logic neg;

  always_comb begin
    neg     = amount[AMT_W-1];
    // 0x8000 negates to itself, read unsigned as 32768.
    mag     = neg ? (~amount + 1'b1) : amount;
    go_left = ~(op_right ^ neg);
  end
endmodule

// File: rtl/sat_left_shift.sv
// Left shift with clamping to the signed range of W bits.
module sat_left_shift #(
  parameter int W     = 16,
  parameter int AMT_W = 16
) (
  input  logic [W-1:0]     x,
  input  logic [AMT_W-1:0] mag,
  output logic [W-1:0]     y,
  output logic             ovf
);
  localparam int SH_W = $clog2(W);
  localparam logic [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

  logic [2*W-1:0] ext;
  logic [2*W-1:0] prod;
  logic [W:0]     hi;
  logic           too_big;
  logic           fits;
  logic           nz;

  always_comb begin
    ext     = {{W{x[W-1]}}, x};
    too_big = (mag >= AMT_W'(W));
    prod    = ext << mag[SH_W-1:0];
    hi      = prod[2*W-1:W-1];
    fits    = (&hi) | ~(|hi);
    nz      = |x;
    ovf     = nz & (too_big | ~fits);
    if (ovf)
      y = x[W-1] ? MIN_V : MAX_V;
    else if (too_big)
      y = '0;
    else
      y = prod[W-1:0];
  end
endmodule

// File: rtl/arith_right_shift.sv
// Arithmetic right shift; counts past W-1 collapse to the sign fill.
module arith_right_shift #(
  parameter int W     = 16,
  parameter int AMT_W = 16
) (
  input  logic [W-1:0]     x,
  input  logic [AMT_W-1:0] mag,
  output logic [W-1:0]     y
);
  localparam int SH_W = $clog2(W);
  localparam logic [SH_W-1:0] CAP = SH_W'(W - 1);

  logic [SH_W-1:0] cnt;

  always_comb begin
    cnt = (mag >= AMT_W'(W - 1)) ? CAP : mag[SH_W-1:0];
    y   = W'($signed(x) >>> cnt);
  end
endmodule

// File: rtl/sat_shift_unit.sv
module sat_shift_unit #(
  parameter int HALF_W = 16,
  parameter int FULL_W = 2 * HALF_W,
  parameter int AMT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        op,
  input  logic [FULL_W-1:0] operand,
  input  logic [AMT_W-1:0]  amount,
  output logic              out_valid,
  output logic [FULL_W-1:0] result,
  output logic              ovf_set
);
  import shift_pkg::*;

  localparam int NWID = 2;

  logic              go_left;
  logic [AMT_W-1:0]  mag;
  logic [FULL_W-1:0] lres [NWID];
  logic [FULL_W-1:0] rres [NWID];
  logic [NWID-1:0]   lovf;
  logic              sel;
  logic [FULL_W-1:0] nxt_res;
  logic              nxt_ovf;

  shamt_resolve #(.AMT_W(AMT_W)) u_amt (
    .op_right (op[0]),
    .amount   (amount),
    .go_left  (go_left),
    .mag      (mag)
  );

  // One left and one right shifter per operand width.
  for (genvar g = 0; g < NWID; g++) begin : g_width
    localparam int W = (g == 0) ? HALF_W : FULL_W;
    logic [W-1:0] ly;
    logic [W-1:0] ry;

    sat_left_shift #(.W(W), .AMT_W(AMT_W)) u_l (
      .x   (operand[W-1:0]),
      .mag (mag),
      .y   (ly),
      .ovf (lovf[g])
    );

    arith_right_shift #(.W(W), .AMT_W(AMT_W)) u_r (
      .x   (operand[W-1:0]),
      .mag (mag),
      .y   (ry)
    );

    assign lres[g] = FULL_W'($signed(ly));
    assign rres[g] = FULL_W'($signed(ry));
  end

  always_comb begin
    sel     = op[1];
    nxt_res = go_left ? lres[sel] : rres[sel];
    nxt_ovf = go_left & lovf[sel];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
      ovf_set   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      ovf_set   <= in_valid & nxt_ovf;
      if (in_valid)
        result <= nxt_res;
    end
  end

  // Checks on the registered outputs.
  localparam logic [FULL_W-1:0] S16_MAX = FULL_W'({1'b0, {(HALF_W-1){1'b1}}});
  localparam logic [FULL_W-1:0] S16_MIN = ~S16_MAX;
  localparam logic [FULL_W-1:0] S32_MAX = {1'b0, {(FULL_W-1){1'b1}}};
  localparam logic [FULL_W-1:0] S32_MIN = ~S32_MAX;

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_ovf_valid_r8: assert property (@(posedge clk) disable iff (rst)
    ovf_set |-> out_valid);

  p_sat_value_r4: assert property (@(posedge clk) disable iff (rst)
    ovf_set |-> (result == S16_MAX || result == S16_MIN ||
                 result == S32_MAX || result == S32_MIN));

  p_zero_no_ovf_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op[1] ? (operand == '0) : (operand[HALF_W-1:0] == '0)))
      |=> (!ovf_set && result == '0));

  p_right_no_ovf_r6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (op[0] ^ amount[AMT_W-1])) |=> !ovf_set);
endmodule

// File: tb/sim_sat_shift_unit.sv
module sim_sat_shift_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] operand = '0;
  logic [15:0] amount = '0;
  logic        out_valid;
  logic [31:0] result;
  logic        ovf_set;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;

  typedef struct {
    logic [31:0] res;
    logic        ovf;
    int          stamp;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sat_shift_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
    .operand(operand), .amount(amount),
    .out_valid(out_valid), .result(result), .ovf_set(ovf_set)
  );

  // Reference model from the requirements, 64-bit arithmetic.
  function automatic exp_t model(logic [1:0] o, logic [31:0] v, logic [15:0] a);
    exp_t e;
    longint w, x, m, p, mx, mn;
    bit left;
    w  = o[1] ? 32 : 16;
    x  = o[1] ? longint'($signed(v)) : longint'($signed(v[15:0]));
    mx = (longint'(1) << (w - 1)) - 1;
    mn = -(longint'(1) << (w - 1));
    left = !o[0];
    m = longint'($signed(a));
    if (m < 0) begin left = !left; m = -m; end
    e.ovf = 1'b0;
    if (left) begin
      if (x == 0) p = 0;
      else if (m >= w) begin p = (x < 0) ? mn : mx; e.ovf = 1'b1; end
      else begin
        p = x * (longint'(1) << m);
        if (p > mx) begin p = mx; e.ovf = 1'b1; end
        else if (p < mn) begin p = mn; e.ovf = 1'b1; end
      end
    end else begin
      if (m > w - 1) m = w - 1;
      p = x >>> m;
    end
    e.res = p[31:0];
    return e;
  endfunction

  task automatic apply(logic [1:0] o, logic [31:0] v, logic [15:0] a, string tag);
    exp_t e;
    @(negedge clk);
    in_valid = 1'b1; op = o; operand = v; amount = a;
    e = model(o, v, a);
    e.stamp = cyc;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic idle_check(string tag);
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || ovf_set !== 1'b0) begin
      n_bad++;
      $display("FAIL %s idle: out_valid=%b ovf_set=%b expected 0 0", tag, out_valid, ovf_set);
    end
  endtask

  // Monitor: pops the scoreboard as results appear.
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        n_chk++;
        if (sb.size() == 0) begin
          n_bad++;
          $display("FAIL R2 unexpected out_valid: result=%h expected none", result);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (result !== e.res || ovf_set !== e.ovf) begin
            n_bad++;
            $display("FAIL %s: result=%h ovf=%b expected %h ovf=%b",
                     e.tag, result, ovf_set, e.res, e.ovf);
          end
        end
      end else if (sb.size() > 0 && sb[0].stamp < cyc) begin
        exp_t e;
        e = sb.pop_front();
        n_chk++; n_bad++;
        $display("FAIL R2 missing result for %s: out_valid=0 expected 1", e.tag);
      end
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        n_chk++;
        if (out_valid !== 1'b0 || result !== '0 || ovf_set !== 1'b0) begin
          n_bad++;
          $display("FAIL R2 reset: v=%b r=%h o=%b expected 0 0 0", out_valid, result, ovf_set);
        end
        // R3 in-range left
        apply(2'b00, 32'h0000_0003, 16'd4, "R3 shl16");
        apply(2'b10, 32'h0001_2345, 16'd8, "R3 shl32");
        apply(2'b00, 32'h0000_FFFF, 16'd15, "R3 shl16 min fits");
        apply(2'b10, 32'hFFFF_FFFF, 16'd31, "R3 shl32 min fits");
        // R4 saturation
        apply(2'b00, 32'h0000_4000, 16'd1, "R4 shl16 pos");
        apply(2'b00, 32'h0000_C000, 16'd2, "R4 shl16 neg");
        apply(2'b00, 32'h0000_0001, 16'd16, "R4 shl16 count16");
        apply(2'b10, 32'h4000_0000, 16'd1, "R4 shl32 pos");
        apply(2'b10, 32'hFFFF_FFFE, 16'd32, "R4 shl32 count32");
        // R5 zero operand
        apply(2'b00, 32'h0000_0000, 16'd20, "R5 shl16 zero");
        apply(2'b10, 32'h0000_0000, 16'h7FFF, "R5 shl32 zero");
        idle_check("R8");
        // R6 right
        apply(2'b01, 32'h0000_8000, 16'd3, "R6 shr16 neg");
        apply(2'b01, 32'h0000_7FFF, 16'd15, "R6 shr16 to zero");
        apply(2'b01, 32'h0000_8000, 16'd100, "R6 shr16 big");
        apply(2'b11, 32'h8000_0000, 16'd31, "R6 shr32 fill");
        apply(2'b11, 32'h1234_5678, 16'd4, "R6 shr32");
        // R7 reversal
        apply(2'b01, 32'h0000_0001, 16'hFFFD, "R7 shr16 neg count");
        apply(2'b00, 32'h0000_0100, 16'hFFFC, "R7 shl16 neg count");
        apply(2'b10, 32'h0000_000F, 16'h8000, "R7 shl32 0x8000");
        apply(2'b01, 32'h0000_0001, 16'h8000, "R7 shr16 0x8000");
        apply(2'b10, 32'hFFFF_FFFB, 16'hFFFF, "R7 shl32 -1");
        // R1 upper bits ignored
        apply(2'b00, 32'hABCD_0002, 16'd1, "R1 shl16 upper");
        apply(2'b01, 32'h1234_8000, 16'd1, "R1 shr16 upper");
        idle_check("R2 gap");
        for (int i = 0; i < 300; i++) begin
          logic [15:0] a;
          a = 16'($urandom);
          if (i % 3 != 0) a = 16'($signed(6'($urandom)));
          apply(2'($urandom), $urandom, a, "R3 R4 R6 R7 random");
        end
        @(negedge clk); in_valid = 1'b0;
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
          n_chk++; n_bad++;
          $display("FAIL R2 leftover: %0d pending expected 0", sb.size());
        end
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run hung, expected completion");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule